// File: doc/BRIEF.md
# Issue Group Hazard Screen

This block sits between a four-wide decode stage and two back ends: a single-issue scalar pipeline and a set of four parallel transport lanes. Decode hands it a group of four already-decoded instructions as one transfer. Each slot carries a slot-valid bit, a destination index, two source indices and an operation class. The screen decides in one step whether the whole group may go to the lanes together. The decision is all or nothing: either all four slots are dispatched to the lanes, or the group returns to scalar issue.

A group qualifies only if four conditions hold. All four slots must be valid. Every slot must be of a lane-capable class. No slot may read a register that an earlier slot in the same group writes. No two writers may share a nonzero destination. Register x0 never links two slots. The decision is combinational. It is captured in one output register together with each slot's register fields, an immediate-select bit and a lane operation code.

Both sides use valid/ready. A group transfers on the input when `in_valid` and `in_ready` are both high. A result transfers on the output when `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the output register holds every field, and `in_ready` stays low, so upstream must keep its group stable. Every accepted group yields exactly one result, whether it is dispatched to the lanes or sent to scalar issue. `out_switch` tells the dispatcher which path to use.

Top module: `grp_dep_checker`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), `out_valid` is low and `in_ready` is high.
- R2: While `out_valid` is high and `out_ready` is low, every output field holds its value, `out_valid` stays high and `in_ready` is low.
- R3: If a group has four valid slots, all of lane-capable classes, and has no hazard, the result has `out_switch`=1 and `out_lane_vld`=4'b1111. Any other group gives `out_switch`=0 and `out_lane_vld`=4'b0000.
- R4: A read-after-write hazard forces `out_switch`=0. This hazard is a slot reading, as a used source, a nonzero register written by a lower-numbered slot. R-type, SW: both sources used. I-type, LW: rs1 only.
- R5: Register x0 links nothing: a write to x0 and a read of x0 never form a hazard.
- R6: Any class code of 17 or above (branch, jump, upper-immediate and others) in any slot forces `out_switch`=0.
- R7: Two writing slots with the same nonzero destination force `out_switch`=0. The same pair writing x0 does not.
- R8: A group with any `in_slot_vld` bit low gives `out_switch`=0.
- R9: These cases form no hazard: a later slot writing a register that an earlier slot reads; the rs2 field of an I-type or LW slot; the rd field of an SW slot.
- R10: Class codes: ADD 0, SUB 1, AND 2, OR 3, XOR 4, SLT 5, SRL 6, SRA 7, ADDI 8, ANDI 9, ORI 10, XORI 11, SLTI 12, SRLI 13, SRAI 14, LW 15, SW 16. Lane op codes: ADD 0, SUB 1, AND 2, OR 3, XOR 4, SLT 5, SRL 6, SRA 7, load 8, store 9. An immediate form takes its base op code with `out_imm_sel`=1. LW and SW also set `out_imm_sel`=1. rd, rs1 and rs2 pass through unchanged.
- R11: A group accepted at one clock edge shows its result with `out_valid` high right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Decoded group offered |
| in_ready | output | 1 | Group can be taken this cycle |
| in_slot_vld | input | LANES | Per-slot valid |
| in_rd | input | LANES*REG_W | Per-slot destination index |
| in_rs1 | input | LANES*REG_W | Per-slot first source index |
| in_rs2 | input | LANES*REG_W | Per-slot second source index |
| in_cls | input | LANES*5 | Per-slot operation class |
| out_valid | output | 1 | Result held for the dispatcher |
| out_ready | input | 1 | Dispatcher takes the result |
| out_switch | output | 1 | 1: parallel lanes, 0: scalar issue |
| out_lane_vld | output | LANES | Per-lane dispatch valid |
| out_rd | output | LANES*REG_W | Destination per slot |
| out_rs1 | output | LANES*REG_W | First source per slot |
| out_rs2 | output | LANES*REG_W | Second source per slot |
| out_imm_sel | output | LANES | Second operand comes from an immediate |
| out_lane_op | output | LANES*4 | Lane operation code |

## Verification
The bench builds the block with its defaults of four lanes and 5-bit register indices. With these values every slot pair in the window can be tested, including the last-slot-to-first-slot pair, and x0 can be named directly. Groups are chosen so that each hazard appears both as a producer-then-consumer pair and as the reversed pair, and both as a used source and as a field that the class ignores. A held-back sink then shows that a pending result freezes while the next group waits at the input.

// File: rtl/grp_chk_pkg.sv
package grp_chk_pkg;
  localparam int CLS_W = 5;
  localparam int OP_W  = 4;

  typedef enum logic [CLS_W-1:0] {
    C_ADD  = 5'd0,  C_SUB  = 5'd1,  C_AND  = 5'd2,  C_OR   = 5'd3,
    C_XOR  = 5'd4,  C_SLT  = 5'd5,  C_SRL  = 5'd6,  C_SRA  = 5'd7,
    C_ADDI = 5'd8,  C_ANDI = 5'd9,  C_ORI  = 5'd10, C_XORI = 5'd11,
    C_SLTI = 5'd12, C_SRLI = 5'd13, C_SRAI = 5'd14, C_LW   = 5'd15,
    C_SW   = 5'd16
  } cls_e;

  typedef enum logic [OP_W-1:0] {
    L_ADD = 4'd0, L_SUB = 4'd1, L_AND = 4'd2, L_OR = 4'd3, L_XOR = 4'd4,
    L_SLT = 4'd5, L_SRL = 4'd6, L_SRA = 4'd7, L_LOAD = 4'd8, L_STORE = 4'd9
  } lop_e;
endpackage

// File: rtl/grp_slot_classify.sv
module grp_slot_classify
  import grp_chk_pkg::*;
(
  input  logic [CLS_W-1:0] cls,
  output logic             ok,
  output logic             use_rs1,
  output logic             use_rs2,
  output logic             writes,
  output logic             imm,
  output logic [OP_W-1:0]  op
);
  always_comb begin
    ok      = 1'b1;
    use_rs1 = 1'b1;
    use_rs2 = 1'b0;
    writes  = 1'b1;
    imm     = 1'b1;
    op      = L_ADD;
    case (cls)
      C_ADD:  begin op = L_ADD; use_rs2 = 1'b1; imm = 1'b0; end
      C_SUB:  begin op = L_SUB; use_rs2 = 1'b1; imm = 1'b0; end
      C_AND:  begin op = L_AND; use_rs2 = 1'b1; imm = 1'b0; end
      C_OR:   begin op = L_OR;  use_rs2 = 1'b1; imm = 1'b0; end
      C_XOR:  begin op = L_XOR; use_rs2 = 1'b1; imm = 1'b0; end
      C_SLT:  begin op = L_SLT; use_rs2 = 1'b1; imm = 1'b0; end
      C_SRL:  begin op = L_SRL; use_rs2 = 1'b1; imm = 1'b0; end
      C_SRA:  begin op = L_SRA; use_rs2 = 1'b1; imm = 1'b0; end
      C_ADDI: op = L_ADD;
      C_ANDI: op = L_AND;
      C_ORI:  op = L_OR;
      C_XORI: op = L_XOR;
      C_SLTI: op = L_SLT;
      C_SRLI: op = L_SRL;
      C_SRAI: op = L_SRA;
      C_LW:   op = L_LOAD;
      C_SW:   begin op = L_STORE; use_rs2 = 1'b1; writes = 1'b0; end
      default: begin
        ok      = 1'b0;
        use_rs1 = 1'b0;
        writes  = 1'b0;
        imm     = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/grp_hazard_matrix.sv
module grp_hazard_matrix #(
  parameter int LANES = 4,
  parameter int REG_W = 5
) (
  input  logic [LANES-1:0]            use_rs1,
  input  logic [LANES-1:0]            use_rs2,
  input  logic [LANES-1:0]            writes,
  input  logic [LANES-1:0][REG_W-1:0] rd,
  input  logic [LANES-1:0][REG_W-1:0] rs1,
  input  logic [LANES-1:0][REG_W-1:0] rs2,
  output logic                        raw_any,
  output logic                        waw_any
);
  logic [LANES-1:0][LANES-1:0] raw_m;
  logic [LANES-1:0][LANES-1:0] waw_m;
  logic [LANES-1:0]            live_wr;

  for (genvar i = 0; i < LANES; i++) begin : g_prod
    assign live_wr[i] = writes[i] && (rd[i] != '0);
    for (genvar j = 0; j < LANES; j++) begin : g_cons
      if (j > i) begin : g_later
        assign raw_m[i][j] = live_wr[i] &&
                             ((use_rs1[j] && (rs1[j] == rd[i])) ||
                              (use_rs2[j] && (rs2[j] == rd[i])));
        assign waw_m[i][j] = live_wr[i] && writes[j] && (rd[j] == rd[i]);
      end else begin : g_none
        assign raw_m[i][j] = 1'b0;
        assign waw_m[i][j] = 1'b0;
      end
    end
  end

  assign raw_any = |raw_m;
  assign waw_any = |waw_m;
endmodule

// File: rtl/grp_pipe_reg.sv
module grp_pipe_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         s_valid,
  output logic         s_ready,
  input  logic [W-1:0] s_data,
  output logic         m_valid,
  input  logic         m_ready,
  output logic [W-1:0] m_data
);
  logic         vld_q;
  logic [W-1:0] data_q;

  assign s_ready = !vld_q || m_ready;
  assign m_valid = vld_q;
  assign m_data  = data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      data_q <= '0;
    end else if (s_valid && s_ready) begin
      vld_q  <= 1'b1;
      data_q <= s_data;
    end else if (m_ready) begin
      vld_q  <= 1'b0;
    end
  end
endmodule

// File: rtl/grp_dep_checker.sv
module grp_dep_checker
  import grp_chk_pkg::*;
#(
  parameter int LANES = 4,
  parameter int REG_W = 5
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [LANES-1:0]            in_slot_vld,
  input  logic [LANES-1:0][REG_W-1:0] in_rd,
  input  logic [LANES-1:0][REG_W-1:0] in_rs1,
  input  logic [LANES-1:0][REG_W-1:0] in_rs2,
  input  logic [LANES-1:0][CLS_W-1:0] in_cls,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic                        out_switch,
  output logic [LANES-1:0]            out_lane_vld,
  output logic [LANES-1:0][REG_W-1:0] out_rd,
  output logic [LANES-1:0][REG_W-1:0] out_rs1,
  output logic [LANES-1:0][REG_W-1:0] out_rs2,
  output logic [LANES-1:0]            out_imm_sel,
  output logic [LANES-1:0][OP_W-1:0]  out_lane_op
);
  localparam int PW = 1 + LANES * (2 + 3 * REG_W + OP_W);

  logic [LANES-1:0]           ok_v, rs1_v, rs2_v, wr_v, imm_v;
  logic [LANES-1:0][OP_W-1:0] op_v;
  logic                       raw_any, waw_any, go_par;
  logic [PW-1:0]              d_pay, q_pay;

  for (genvar s = 0; s < LANES; s++) begin : g_slot
    grp_slot_classify u_cls (
      .cls     (in_cls[s]),
      .ok      (ok_v[s]),
      .use_rs1 (rs1_v[s]),
      .use_rs2 (rs2_v[s]),
      .writes  (wr_v[s]),
      .imm     (imm_v[s]),
      .op      (op_v[s])
    );
  end

  grp_hazard_matrix #(.LANES(LANES), .REG_W(REG_W)) u_haz (
    .use_rs1 (rs1_v),
    .use_rs2 (rs2_v),
    .writes  (wr_v),
    .rd      (in_rd),
    .rs1     (in_rs1),
    .rs2     (in_rs2),
    .raw_any (raw_any),
    .waw_any (waw_any)
  );

  assign go_par = (&in_slot_vld) && (&ok_v) && !raw_any && !waw_any;
  assign d_pay  = {go_par, {LANES{go_par}}, in_rd, in_rs1, in_rs2, imm_v, op_v};

  grp_pipe_reg #(.W(PW)) u_out (
    .clk     (clk),
    .rst     (rst),
    .s_valid (in_valid),
    .s_ready (in_ready),
    .s_data  (d_pay),
    .m_valid (out_valid),
    .m_ready (out_ready),
    .m_data  (q_pay)
  );

  assign {out_switch, out_lane_vld, out_rd, out_rs1, out_rs2, out_imm_sel, out_lane_op} = q_pay;
endmodule

// File: rtl/grp_dep_checker_sva.sv
module grp_dep_checker_sva
  import grp_chk_pkg::*;
#(
  parameter int LANES = 4,
  parameter int REG_W = 5
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        in_valid,
  input logic                        in_ready,
  input logic [LANES-1:0]            in_slot_vld,
  input logic [LANES-1:0][CLS_W-1:0] in_cls,
  input logic                        out_valid,
  input logic                        out_ready,
  input logic                        out_switch,
  input logic [LANES-1:0]            out_lane_vld,
  input logic [LANES-1:0][REG_W-1:0] out_rd,
  input logic [LANES-1:0][OP_W-1:0]  out_lane_op
);
  logic bad_cls;
  always_comb begin
    bad_cls = 1'b0;
    for (int k = 0; k < LANES; k++)
      if (in_cls[k] > CLS_W'(16)) bad_cls = 1'b1;
  end

  a_reset_r1: assert property (@(posedge clk) rst |=> !out_valid);

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_switch) &&
      $stable(out_lane_vld) && $stable(out_rd) && $stable(out_lane_op));

  p_stall_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready);

  p_all_or_none_r3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_switch ? (&out_lane_vld) : (out_lane_vld == '0)));

  p_bad_class_r6: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && bad_cls |=> !out_switch);

  p_partial_r8: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && !(&in_slot_vld) |=> !out_switch);

  p_latency_r11: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid);
endmodule

bind grp_dep_checker grp_dep_checker_sva #(.LANES(LANES), .REG_W(REG_W)) u_sva (
  .clk          (clk),
  .rst          (rst),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .in_slot_vld  (in_slot_vld),
  .in_cls       (in_cls),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_switch   (out_switch),
  .out_lane_vld (out_lane_vld),
  .out_rd       (out_rd),
  .out_lane_op  (out_lane_op)
);

// File: tb/grp_dep_checker_tb_top.sv
module grp_dep_checker_tb_top;
  localparam int LANES = 4;
  localparam int REG_W = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [LANES-1:0] in_slot_vld = '0;
  logic [LANES-1:0][REG_W-1:0] in_rd = '0, in_rs1 = '0, in_rs2 = '0;
  logic [LANES-1:0][4:0] in_cls = '0;
  logic out_valid, out_switch;
  logic out_ready = 1'b1;
  logic [LANES-1:0] out_lane_vld, out_imm_sel;
  logic [LANES-1:0][REG_W-1:0] out_rd, out_rs1, out_rs2;
  logic [LANES-1:0][3:0] out_lane_op;

  always #2 clk = ~clk;

  grp_dep_checker #(.LANES(LANES), .REG_W(REG_W)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_slot_vld(in_slot_vld), .in_rd(in_rd), .in_rs1(in_rs1), .in_rs2(in_rs2),
    .in_cls(in_cls), .out_valid(out_valid), .out_ready(out_ready),
    .out_switch(out_switch), .out_lane_vld(out_lane_vld), .out_rd(out_rd),
    .out_rs1(out_rs1), .out_rs2(out_rs2), .out_imm_sel(out_imm_sel),
    .out_lane_op(out_lane_op)
  );

  typedef struct {
    logic                        sw;
    logic [LANES-1:0][REG_W-1:0] rd, rs1, rs2;
    logic [LANES-1:0][3:0]       op;
    logic [LANES-1:0]            imm;
    string                       tag;
  } exp_t;

  exp_t sb[$];
  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] op_of(input int c);
    case (c)
      0, 8:  return 4'd0;
      1:     return 4'd1;
      2, 9:  return 4'd2;
      3, 10: return 4'd3;
      4, 11: return 4'd4;
      5, 12: return 4'd5;
      6, 13: return 4'd6;
      7, 14: return 4'd7;
      15:    return 4'd8;
      16:    return 4'd9;
      default: return 4'd0;
    endcase
  endfunction

  logic [LANES-1:0] g_vld;
  logic [LANES-1:0][REG_W-1:0] g_rd, g_rs1, g_rs2;
  logic [LANES-1:0][4:0] g_cls;

  task automatic put(input int s, input int rd, input int r1, input int r2, input int c);
    g_rd[s] = REG_W'(rd); g_rs1[s] = REG_W'(r1); g_rs2[s] = REG_W'(r2); g_cls[s] = 5'(c);
  endtask

  task automatic build(input bit sw, input string tag, output exp_t e);
    e.sw = sw; e.rd = g_rd; e.rs1 = g_rs1; e.rs2 = g_rs2; e.tag = tag;
    for (int s = 0; s < LANES; s++) begin
      e.op[s]  = op_of(int'(g_cls[s]));
      e.imm[s] = (g_cls[s] >= 5'd8) && (g_cls[s] <= 5'd16);
    end
  endtask

  task automatic apply_inputs();
    in_slot_vld = g_vld; in_rd = g_rd; in_rs1 = g_rs1; in_rs2 = g_rs2; in_cls = g_cls;
    in_valid = 1'b1;
  endtask

  task automatic send(input bit sw, input string tag);
    exp_t e;
    build(sw, tag, e);
    @(posedge clk); #1;
    apply_inputs();
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    sb.push_back(e);
    @(posedge clk); #1;
    in_valid = 1'b0;
    g_vld = '1;
    @(negedge clk);
    chk(out_valid == 1'b1, "R11", {tag, " out_valid after accept"}, out_valid, 1);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && out_valid && out_ready) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R3", "unexpected result", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(out_switch == e.sw, "R3", {e.tag, " switch"}, out_switch, e.sw);
        chk(out_lane_vld == (e.sw ? 4'hF : 4'h0), "R3", {e.tag, " lane_vld"},
            out_lane_vld, e.sw ? 4'hF : 4'h0);
        chk(out_rd == e.rd && out_rs1 == e.rs1 && out_rs2 == e.rs2, "R10",
            {e.tag, " reg fields"}, {out_rd, out_rs1, out_rs2}, {e.rd, e.rs1, e.rs2});
        if (e.sw) begin
          chk(out_lane_op == e.op, "R10", {e.tag, " lane op"}, out_lane_op, e.op);
          chk(out_imm_sel == e.imm, "R10", {e.tag, " imm sel"}, out_imm_sel, e.imm);
        end
      end
    end
  end

  initial begin
    #400000;
    chk(1'b0, "R11", "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    exp_t eb;
    logic [LANES-1:0][REG_W-1:0] snap_rd;
    logic snap_sw;
    g_vld = '1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);

    // R3 independent register-register group
    put(0, 11, 2, 0, 0); put(1, 15, 5, 5, 1); put(2, 25, 6, 10, 4); put(3, 7, 8, 9, 7);
    send(1, "R3 independent");
    // R10 immediate, load, store codes
    put(0, 3, 1, 0, 8); put(1, 4, 1, 0, 13); put(2, 6, 1, 0, 15); put(3, 0, 2, 12, 16);
    send(1, "R10 imm/ld/st");
    // R4 hazard through rs2
    put(0, 5, 1, 2, 0); put(1, 6, 3, 4, 3); put(2, 8, 7, 5, 2); put(3, 9, 1, 1, 5);
    send(0, "R4 raw rs2");
    // R4 load result consumed by next slot rs1
    put(0, 12, 1, 0, 15); put(1, 13, 12, 0, 8); put(2, 14, 1, 2, 0); put(3, 16, 1, 2, 0);
    send(0, "R4 raw load");
    // R4 first writer, last reader
    put(0, 30, 1, 2, 0); put(1, 14, 1, 2, 0); put(2, 16, 1, 2, 0); put(3, 17, 2, 30, 1);
    send(0, "R4 raw far");
    // R9 reversed order
    put(0, 20, 3, 4, 0); put(1, 21, 1, 2, 0); put(2, 22, 1, 2, 0); put(3, 3, 1, 2, 1);
    send(1, "R9 war");
    // R9 ignored rs2 of I-type
    put(0, 14, 1, 2, 0); put(1, 15, 1, 14, 9); put(2, 16, 1, 2, 3); put(3, 17, 1, 2, 4);
    send(1, "R9 imm rs2");
    // R9 SW rd field ignored
    put(0, 18, 1, 2, 16); put(1, 19, 18, 2, 0); put(2, 20, 1, 2, 0); put(3, 21, 1, 18, 2);
    send(1, "R9 sw rd");
    // R5 x0
    put(0, 0, 1, 2, 0); put(1, 10, 0, 0, 0); put(2, 11, 0, 1, 11); put(3, 12, 1, 0, 12);
    send(1, "R5 x0");
    // R6 ineligible class
    put(0, 4, 1, 2, 0); put(1, 5, 1, 2, 0); put(2, 6, 1, 2, 17); put(3, 7, 1, 2, 0);
    send(0, "R6 class17");
    put(0, 4, 1, 2, 31);
    send(0, "R6 class31");
    // R7 same destination
    put(0, 4, 1, 2, 0); put(1, 9, 1, 2, 0); put(2, 6, 1, 2, 0); put(3, 9, 1, 2, 8);
    send(0, "R7 waw");
    put(0, 0, 1, 2, 0); put(1, 9, 1, 2, 0); put(2, 0, 3, 4, 0); put(3, 10, 1, 2, 8);
    send(1, "R7 waw x0");
    // R8 partial groups
    put(0, 4, 1, 2, 0); put(1, 5, 1, 2, 0); put(2, 6, 1, 2, 0); put(3, 7, 1, 2, 0);
    g_vld = 4'b0111;
    send(0, "R8 partial hi");
    g_vld = 4'b1110;
    send(0, "R8 partial lo");

    // R2 back-pressure
    @(posedge clk); #1 out_ready = 1'b0;
    put(0, 11, 2, 0, 0); put(1, 15, 5, 5, 1); put(2, 25, 6, 10, 4); put(3, 7, 8, 9, 7);
    send(1, "R2 first");
    snap_rd = out_rd; snap_sw = out_switch;
    put(0, 5, 1, 2, 0); put(1, 6, 3, 4, 3); put(2, 8, 7, 5, 2); put(3, 9, 1, 1, 5);
    build(0, "R2 second", eb);
    @(posedge clk); #1;
    apply_inputs();
    sb.push_back(eb);
    for (int n = 0; n < 4; n++) begin
      @(negedge clk);
      chk(in_ready == 1'b0, "R2", "in_ready while stalled", in_ready, 0);
      chk(out_valid == 1'b1 && out_switch == snap_sw && out_rd == snap_rd, "R2",
          "held output", {out_valid, out_switch, out_rd}, {1'b1, snap_sw, snap_rd});
    end
    @(posedge clk); #1 out_ready = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R2", "in_ready on release", in_ready, 1);
    @(posedge clk); #1 in_valid = 1'b0;
    repeat (4) @(negedge clk);
    chk(sb.size() == 0, "R3", "scoreboard drained", sb.size(), 0);
    chk(out_valid == 1'b0, "R11", "idle after drain", out_valid, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule